// File: doc/BRIEF.md
# Command Source Arbiter

This block decides which command stream feeds the command parser at any moment. It chooses between a low-priority ring, an interrupt-priority ring, and a batch buffer. The batch buffer can be entered from either ring, and the block records which ring entered it so that control goes back to the same ring when the batch ends.

Moving away from a ring that is being parsed needs the command pipeline drained first. The block does this through dedicated switch states. Each switch state raises a request to an external drain sequencer and waits for a completion pulse before it enters its target state.

A 4-bit readback exposes the exact arbitration state. The encoding is fixed so that other logic can decode it. The reset is asserted asynchronously and released through a small synchronizer.

Top module: `cmd_src_arb`

## Requirements
- R1: While reset is asserted, and after it is released with all inputs low, the state readback is 0000, the source select is 00 and the switch request is low.
- R2: The state readback uses these codes: 0000 idle, 0001 low ring active, 0010 low-to-interrupt switch, 0011 batch from low ring, 0100 low-to-batch switch, 0101 interrupt ring active, 0110 interrupt-to-batch switch, 0111 batch from interrupt ring, 1000 interrupt-to-idle switch. Each transition appears on the readback one clock edge after the deciding inputs are sampled.
- R3: From idle, a pending interrupt ring selects 0101, even when the low ring is also pending. If only the low ring is pending, 0001 is selected.
- R4: In 0001 the first matching condition applies, in this order: a batch start goes to 0100; a parser yield (the low ring valid bit masked) goes to 0010; a low ring with no pending commands goes to 0000.
- R5: In 0101 the first matching condition applies, in this order: a batch start goes to 0110; a wait-for-event goes to 1000; an interrupt ring with no pending commands goes to 0000.
- R6: The switch request is high exactly in the switch states 0010, 0100, 0110 and 1000. A switch state holds until switch-complete is sampled high. It then enters its target: 0010 to 0101, 0100 to 0011, 0110 to 0111, 1000 to 0000.
- R7: A batch end moves 0011 directly to 0001 and 0111 directly to 0101, with no switch state and no switch request.
- R8: The source select is 00 in idle; 01 (low ring) in 0001, 0010 and 0100; 10 (interrupt ring) in 0101, 0110 and 1000; and 11 (batch) in 0011 and 0111.
- R9: Inputs that do not apply to the current state have no effect. Batch end and switch-complete do not change a ring-active state. Batch start, yield, wait-for-event, switch-complete and the ring pending flags do not change a batch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lo_pend_i | input | 1 | Low-priority ring has commands |
| int_pend_i | input | 1 | Interrupt-priority ring has commands |
| lo_yield_i | input | 1 | Parser masked the low ring valid bit to yield |
| batch_start_i | input | 1 | Parser begins a batch buffer |
| batch_end_i | input | 1 | Parser reached the end of the batch buffer |
| wait_evt_i | input | 1 | Wait-for-event packet seen on the interrupt ring |
| sw_done_i | input | 1 | Drain sequencer finished the requested switch |
| src_sel_o | output | 2 | Active command source |
| sw_req_o | output | 1 | Switch request to the drain sequencer |
| state_rd_o | output | 4 | Arbitration state readback |

## Verification
A directed walk first visits every state and every exit edge. It covers both rings pending together in idle, a wait-for-event drain, a batch round trip from each ring, and a switch held open over cycles without completion. This separates correct priority and correct return-ring tracking from a design that merely reaches the right states by another path.

Irrelevant pulses are then applied in ring-active and batch states to show that they are ignored. Biased random input vectors cover the remaining cases. They give frequent switch-complete pulses and rarer batch and wait events, so that simultaneous and conflicting conditions are exercised and the priority order within each state is stressed.

// File: rtl/cmd_src_arb_pkg.sv
package cmd_src_arb_pkg;

  localparam int unsigned ST_W  = 4;
  localparam int unsigned SRC_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 4'b0000,
    ST_LOW  = 4'b0001,
    ST_L2I  = 4'b0010,
    ST_LBAT = 4'b0011,
    ST_L2B  = 4'b0100,
    ST_INTR = 4'b0101,
    ST_I2B  = 4'b0110,
    ST_IBAT = 4'b0111,
    ST_I2D  = 4'b1000
  } arb_state_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE  = 2'b00,
    SRC_LOW   = 2'b01,
    SRC_INT   = 2'b10,
    SRC_BATCH = 2'b11
  } src_e;

  typedef struct packed {
    logic lo_pend;
    logic int_pend;
    logic lo_yield;
    logic batch_start;
    logic batch_end;
    logic wait_evt;
    logic sw_done;
  } arb_in_t;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned MSB = STAGES - 1;

  logic [MSB:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[MSB-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[MSB];

endmodule

// File: rtl/arb_next.sv
module arb_next
  import cmd_src_arb_pkg::*;
(
  input  arb_state_e cur_i,
  input  arb_in_t    in_i,
  output arb_state_e nxt_o
);

  always_comb begin
    nxt_o = cur_i;
    unique case (cur_i)
      ST_IDLE: begin
        if (in_i.int_pend)     nxt_o = ST_INTR;
        else if (in_i.lo_pend) nxt_o = ST_LOW;
      end
      ST_LOW: begin
        if (in_i.batch_start)   nxt_o = ST_L2B;
        else if (in_i.lo_yield) nxt_o = ST_L2I;
        else if (!in_i.lo_pend) nxt_o = ST_IDLE;
      end
      ST_INTR: begin
        if (in_i.batch_start)    nxt_o = ST_I2B;
        else if (in_i.wait_evt)  nxt_o = ST_I2D;
        else if (!in_i.int_pend) nxt_o = ST_IDLE;
      end
      ST_L2I: if (in_i.sw_done) nxt_o = ST_INTR;
      ST_L2B: if (in_i.sw_done) nxt_o = ST_LBAT;
      ST_I2B: if (in_i.sw_done) nxt_o = ST_IBAT;
      ST_I2D: if (in_i.sw_done) nxt_o = ST_IDLE;
      ST_LBAT: if (in_i.batch_end) nxt_o = ST_LOW;
      ST_IBAT: if (in_i.batch_end) nxt_o = ST_INTR;
      default: nxt_o = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/arb_decode.sv
module arb_decode
  import cmd_src_arb_pkg::*;
(
  input  arb_state_e st_i,
  output src_e       src_o,
  output logic       sw_req_o
);

  always_comb begin
    src_o    = SRC_NONE;
    sw_req_o = 1'b0;
    unique case (st_i)
      ST_IDLE: src_o = SRC_NONE;
      ST_LOW:  src_o = SRC_LOW;
      ST_L2I, ST_L2B: begin
        src_o    = SRC_LOW;
        sw_req_o = 1'b1;
      end
      ST_INTR: src_o = SRC_INT;
      ST_I2B, ST_I2D: begin
        src_o    = SRC_INT;
        sw_req_o = 1'b1;
      end
      ST_LBAT, ST_IBAT: src_o = SRC_BATCH;
      default: begin
        src_o    = SRC_NONE;
        sw_req_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/cmd_src_arb.sv
module cmd_src_arb
  import cmd_src_arb_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_pend_i,
  input  logic       int_pend_i,
  input  logic       lo_yield_i,
  input  logic       batch_start_i,
  input  logic       batch_end_i,
  input  logic       wait_evt_i,
  input  logic       sw_done_i,
  output logic [1:0] src_sel_o,
  output logic       sw_req_o,
  output logic [3:0] state_rd_o
);

  logic       rst_int_n;
  arb_in_t    in_s;
  arb_state_e state_q;
  arb_state_e state_d;
  src_e       src_s;
  logic       sw_req_s;

  arb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign in_s = '{
    lo_pend:     lo_pend_i,
    int_pend:    int_pend_i,
    lo_yield:    lo_yield_i,
    batch_start: batch_start_i,
    batch_end:   batch_end_i,
    wait_evt:    wait_evt_i,
    sw_done:     sw_done_i
  };

  arb_next u_next (
    .cur_i (state_q),
    .in_i  (in_s),
    .nxt_o (state_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  arb_decode u_dec (
    .st_i     (state_q),
    .src_o    (src_s),
    .sw_req_o (sw_req_s)
  );

  assign src_sel_o  = src_s;
  assign sw_req_o   = sw_req_s;
  assign state_rd_o = state_q;

  AST_IDLE_INT_FIRST: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_rd_o == 4'b0000 && int_pend_i) |=> (state_rd_o == 4'b0101)); // R3

  AST_INT_WAIT_DRAIN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_rd_o == 4'b0101 && wait_evt_i && !batch_start_i) |=> (state_rd_o == 4'b1000)); // R5

  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sw_req_o && !sw_done_i) |=> (sw_req_o && $stable(state_rd_o))); // R6

  AST_SW_EXIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sw_req_o && sw_done_i) |=> !sw_req_o); // R6

  AST_LBAT_RETURN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_rd_o == 4'b0011 && batch_end_i) |=> (state_rd_o == 4'b0001 && !sw_req_o)); // R7

  AST_IBAT_RETURN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_rd_o == 4'b0111 && batch_end_i) |=> (state_rd_o == 4'b0101 && !sw_req_o)); // R7

  AST_BATCH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (src_sel_o == 2'b11) |-> !sw_req_o); // R8

  AST_BATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (src_sel_o == 2'b11 && !batch_end_i) |=> (src_sel_o == 2'b11)); // R9

endmodule

// File: tb/sim_cmd_src_arb.sv
module sim_cmd_src_arb;

  localparam int CLK_PERIOD = 10;
  localparam int RST_STAGES = 2;
  localparam int N_RANDOM   = 4000;

  localparam logic [6:0] V_LO = 7'b1000000;
  localparam logic [6:0] V_IN = 7'b0100000;
  localparam logic [6:0] V_YL = 7'b0010000;
  localparam logic [6:0] V_BS = 7'b0001000;
  localparam logic [6:0] V_BE = 7'b0000100;
  localparam logic [6:0] V_WE = 7'b0000010;
  localparam logic [6:0] V_SD = 7'b0000001;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lo_pend, int_pend, lo_yield, batch_start, batch_end, wait_evt, sw_done;
  logic [1:0] src_sel;
  logic       sw_req;
  logic [3:0] state_rd;

  int         errors = 0;
  int         checks = 0;
  logic [3:0] exp_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_src_arb #(.RST_STAGES(RST_STAGES)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .lo_pend_i     (lo_pend),
    .int_pend_i    (int_pend),
    .lo_yield_i    (lo_yield),
    .batch_start_i (batch_start),
    .batch_end_i   (batch_end),
    .wait_evt_i    (wait_evt),
    .sw_done_i     (sw_done),
    .src_sel_o     (src_sel),
    .sw_req_o      (sw_req),
    .state_rd_o    (state_rd)
  );

  function automatic logic [3:0] model(input logic [3:0] s, input logic [6:0] v);
    logic lo, in, yl, bs, be, we, sd;
    {lo, in, yl, bs, be, we, sd} = v;
    case (s)
      4'h0: return in ? 4'h5 : (lo ? 4'h1 : 4'h0);
      4'h1: return bs ? 4'h4 : (yl ? 4'h2 : (!lo ? 4'h0 : 4'h1));
      4'h5: return bs ? 4'h6 : (we ? 4'h8 : (!in ? 4'h0 : 4'h5));
      4'h2: return sd ? 4'h5 : s;
      4'h4: return sd ? 4'h3 : s;
      4'h6: return sd ? 4'h7 : s;
      4'h8: return sd ? 4'h0 : s;
      4'h3: return be ? 4'h1 : s;
      4'h7: return be ? 4'h5 : s;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [1:0] exp_src(input logic [3:0] s);
    case (s)
      4'h1, 4'h2, 4'h4: return 2'b01;
      4'h5, 4'h6, 4'h8: return 2'b10;
      4'h3, 4'h7:       return 2'b11;
      default:          return 2'b00;
    endcase
  endfunction

  function automatic logic exp_req(input logic [3:0] s);
    return (s == 4'h2) || (s == 4'h4) || (s == 4'h6) || (s == 4'h8);
  endfunction

  function automatic string tag_of(input logic [3:0] s);
    case (s)
      4'h0:                   return "R3";
      4'h1:                   return "R4";
      4'h5:                   return "R5";
      4'h2, 4'h4, 4'h6, 4'h8: return "R6";
      default:                return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp_v, input string what);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp_v, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag,  int'(state_rd), int'(exp_st),          "state (R2)");
    chk("R8", int'(src_sel),  int'(exp_src(exp_st)), "source select");
    chk("R6", int'(sw_req),   int'(exp_req(exp_st)), "switch request");
  endtask

  task automatic step(input logic [6:0] v, input string tag);
    {lo_pend, int_pend, lo_yield, batch_start, batch_end, wait_evt, sw_done} = v;
    exp_st = model(exp_st, v);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [6:0] v;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    {lo_pend, int_pend, lo_yield, batch_start, batch_end, wait_evt, sw_done} = '0;
    exp_st = 4'h0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (RST_STAGES + 2) @(negedge clk);
    check_all("R1");

    // directed walk
    step(V_LO | V_IN,        "R3");  // both pending -> interrupt ring
    step(V_IN | V_WE,        "R5");  // wait-for-event -> drain to idle
    step(V_IN,               "R6");  // hold without completion
    step(V_IN | V_BE,        "R6");  // still holding
    step(V_IN | V_SD,        "R6");  // -> idle
    step(V_LO,               "R3");  // low only -> low ring
    step(V_LO | V_BE | V_SD, "R9");  // ignored in ring state
    step(V_LO | V_BS,        "R4");  // -> low-to-batch switch
    step(V_LO | V_SD,        "R6");  // -> batch from low
    step(V_BS | V_SD | V_YL | V_WE | V_IN, "R9"); // ignored in batch
    step(V_BE,               "R7");  // direct return to low ring
    step(V_LO | V_YL | V_IN, "R4");  // yield -> low-to-interrupt
    step(V_IN | V_SD,        "R6");  // -> interrupt ring
    step(V_IN | V_BS | V_WE, "R5");  // batch start beats wait
    step(V_IN | V_SD,        "R6");  // -> batch from interrupt
    step(V_LO | V_SD,        "R9");  // ignored in batch
    step(V_IN | V_BE,        "R7");  // direct return to interrupt ring
    step(V_IN | V_BE | V_SD, "R9");  // ignored in ring state
    step('0,                 "R5");  // empty interrupt ring -> idle
    step(V_LO,               "R3");
    step(V_LO | V_BS | V_YL, "R4");  // batch start beats yield
    step(V_SD,               "R6");
    step(V_BE | V_LO,        "R7");
    step('0,                 "R4");  // empty low ring -> idle

    // biased random
    for (int i = 0; i < N_RANDOM; i++) begin
      v[6] = ($urandom_range(99) < 70);
      v[5] = ($urandom_range(99) < 30);
      v[4] = ($urandom_range(99) < 15);
      v[3] = ($urandom_range(99) < 10);
      v[2] = ($urandom_range(99) < 20);
      v[1] = ($urandom_range(99) < 10);
      v[0] = ($urandom_range(99) < 40);
      step(v, tag_of(exp_st));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule